// File: doc/BRIEF.md
# Capability Trap Entry and Fault Cause Unit

This block holds the capability that governs instruction fetch, a saved copy of it for exception return, and the privileged handler capability that exceptions jump into. On every exception it parks the running fetch capability in the saved slot. It then loads the handler capability as the new fetch capability, with only the pointer offset replaced by the exception vector. On exception return the saved capability, with any offset that software has patched, becomes the fetch capability again.

The block also keeps a small fault-cause register that describes the most recent capability fault: a fault code and the number of the register involved. Software may read it or write high-range codes into it. Both accesses are guarded by a system-register permission bit on the current fetch capability. An access without that permission is itself a capability fault. The block also drives the processor-level exception code that the trap logic reports.

Top module: `cap_trap_unit`

## Requirements
- R1: After reset the fetch and handler capabilities are tag=1, sealed=0, all 16 permission bits set, object type 0, base 0, length all ones and offset 0. The saved capability is all zero, the exception code is 0 and the cause register reads 0x0000. The capability vector is packed from the MSB down as tag(1), sealed(1), perms(16), otype(24), base(64), length(64), offset(64).
- R2: On the edge that takes any exception, the saved capability receives the fetch capability that was current before that edge.
- R3: On the same edge, the fetch capability becomes the handler capability with its offset replaced by `vec_offset`; all other fields come from the handler capability.
- R4: An `eret` pulse with no exception copies the saved capability into the fetch capability. A prior `epcc_off_wr` changes only the saved offset, and the return uses that new offset.
- R5: When an exception and `eret` arrive together, the exception is taken and the return is dropped. An exception also overrides fetch-offset and saved-offset writes in the same cycle.
- R6: A capability exception sets the exception code to 18 and loads the cause register with code in bits 15:8 and register number in bits 7:0. It wins over a generic exception in the same cycle.
- R7: A generic exception with no capability fault sets the exception code to `gen_exc_code` and clears the cause register to 0x0000.
- R8: A cause read or set needs fetch-capability permission bit 10. With it, a read returns the cause register on `cause_rd_data` with `cause_rd_valid` high one cycle later. Without it, no data is returned and a capability exception with code 0x18 and register number 0xFF is taken.
- R9: A permitted set with a code of 0x80 or above writes that code into bits 15:8 and keeps bits 7:0.
- R10: A permitted set with a code below 0x80 leaves the cause register unchanged.
- R11: `kcc_wr` loads a new handler capability, and later exceptions use it.
- R12: `pc_off_wr` replaces the fetch offset when no exception or return is taken that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_exc | input | 1 | Capability exception pulse |
| cap_exc_code | input | 8 | Capability fault code |
| cap_exc_reg | input | 8 | Register number of the fault |
| gen_exc | input | 1 | Generic exception pulse |
| gen_exc_code | input | 5 | Exception code for a generic exception |
| vec_offset | input | 64 | Exception vector offset |
| eret | input | 1 | Exception return pulse |
| pc_off_wr | input | 1 | Fetch-offset update strobe |
| pc_off_data | input | 64 | New fetch offset |
| epcc_off_wr | input | 1 | Saved-offset write strobe |
| epcc_off_data | input | 64 | New saved offset |
| kcc_wr | input | 1 | Handler capability write strobe |
| kcc_wdata | input | 234 | New handler capability |
| cause_rd | input | 1 | Cause register read request |
| cause_set | input | 1 | Cause register set request |
| cause_set_code | input | 8 | Code for a set request |
| pcc_o | output | 234 | Current fetch capability |
| epcc_o | output | 234 | Saved capability |
| exc_code_o | output | 5 | Processor exception code |
| cause_rd_valid | output | 1 | Read data valid |
| cause_rd_data | output | 16 | Read data |

## Verification
Entry is tried from several fetch offsets and with two handler capabilities. One has a distinct base, length and reduced permissions, which separates a copy of the whole handler capability from a copy of only its offset. Return is tried after a patched saved offset, and again colliding with an entry, so the priority order shows in the fetch offset. Cause-set codes 0x7F, 0x80 and 0x85 straddle the software threshold. Reads run both with and without the system-register permission, which separates a granted read from a fault that redirects fetch.

// File: rtl/cap_trap_pkg.sv
package cap_trap_pkg;
  localparam int ADDR_W      = 64;
  localparam int PERM_W      = 16;
  localparam int OTYPE_W     = 24;
  localparam int CODE_W      = 8;
  localparam int REGN_W      = 8;
  localparam int EXC_W       = 5;
  localparam int PERM_SYSREG = 10;

  localparam logic [EXC_W-1:0]  EXC_CAP     = EXC_W'(18);
  localparam logic [CODE_W-1:0] CODE_SYSREG = 8'h18;
  localparam logic [CODE_W-1:0] CODE_SW_MIN = 8'h80;
  localparam logic [REGN_W-1:0] REG_FETCH   = 8'hFF;

  typedef struct packed {
    logic               tag;
    logic               sealed;
    logic [PERM_W-1:0]  perms;
    logic [OTYPE_W-1:0] otype;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  length;
    logic [ADDR_W-1:0]  offset;
  } cap_t;

  localparam int CAP_W = $bits(cap_t);

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [REGN_W-1:0] regn;
  } cause_t;

  localparam int CAUSE_W = $bits(cause_t);

  function automatic cap_t boot_cap();
    cap_t c;
    c        = '0;
    c.tag    = 1'b1;
    c.perms  = '1;
    c.length = '1;
    return c;
  endfunction

  function automatic cap_t vector_into(cap_t k, logic [ADDR_W-1:0] v);
    cap_t r;
    r        = k;
    r.offset = v;
    return r;
  endfunction

  function automatic logic sw_code_ok(logic [CODE_W-1:0] c);
    return c >= CODE_SW_MIN;
  endfunction

  function automatic logic has_sysreg(cap_t c);
    return c.perms[PERM_SYSREG];
  endfunction
endpackage

// File: rtl/cap_pcc_seq.sv
module cap_pcc_seq
  import cap_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              eret,
  input  logic [ADDR_W-1:0] vec_offset,
  input  logic              pc_off_wr,
  input  logic [ADDR_W-1:0] pc_off_data,
  input  logic              epcc_off_wr,
  input  logic [ADDR_W-1:0] epcc_off_data,
  input  logic              kcc_wr,
  input  cap_t              kcc_data,
  output cap_t              pcc_q,
  output cap_t              epcc_q
);
  cap_t kcc_q;

  logic take_ret;
  logic take_pc_wr;
  logic take_epcc_wr;

  assign take_ret     = eret & ~enter;
  assign take_pc_wr   = pc_off_wr & ~enter & ~eret;
  assign take_epcc_wr = epcc_off_wr & ~enter;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcc_q  <= boot_cap();
      kcc_q  <= boot_cap();
      epcc_q <= '0;
    end else begin
      if (kcc_wr) kcc_q <= kcc_data;
      if (enter) begin
        epcc_q <= pcc_q;
        pcc_q  <= vector_into(kcc_q, vec_offset);
      end else begin
        if (take_ret)     pcc_q         <= epcc_q;
        if (take_pc_wr)   pcc_q.offset  <= pc_off_data;
        if (take_epcc_wr) epcc_q.offset <= epcc_off_data;
      end
    end
  end

  // R2
  a_r2_save_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> epcc_q == $past(pcc_q));
  // R3
  a_r3_vector_offset: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> pcc_q.offset == $past(vec_offset));
  // R4
  a_r4_return: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !enter) |=> pcc_q == $past(epcc_q));
  // R5
  a_r5_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && eret) |=> (pcc_q.offset == $past(vec_offset) && epcc_q == $past(pcc_q)));
endmodule

// File: rtl/cap_cause_reg.sv
module cap_cause_reg
  import cap_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_exc,
  input  logic [CODE_W-1:0] cap_code,
  input  logic [REGN_W-1:0] cap_reg,
  input  logic              gen_exc,
  input  logic [EXC_W-1:0]  gen_code,
  input  logic              rd_req,
  input  logic              set_req,
  input  logic [CODE_W-1:0] set_code,
  input  logic              pcc_sysreg,
  output logic              enter,
  output logic [EXC_W-1:0]  exc_code_q,
  output logic              rd_valid,
  output cause_t            rd_data
);
  cause_t cause_q;

  logic access;
  logic denied;
  logic cap_event;
  logic grant_rd;
  logic grant_set;

  assign access    = rd_req | set_req;
  assign denied    = access & ~pcc_sysreg;
  assign cap_event = cap_exc | denied;
  assign enter     = cap_event | gen_exc;
  assign grant_rd  = rd_req & pcc_sysreg;
  assign grant_set = set_req & pcc_sysreg & sw_code_ok(set_code) & ~enter;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q    <= '0;
      exc_code_q <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      if (cap_exc)        cause_q <= '{code: cap_code, regn: cap_reg};
      else if (denied)    cause_q <= '{code: CODE_SYSREG, regn: REG_FETCH};
      else if (gen_exc)   cause_q <= '0;
      else if (grant_set) cause_q.code <= set_code;

      if (cap_event)    exc_code_q <= EXC_CAP;
      else if (gen_exc) exc_code_q <= gen_code;

      rd_valid <= grant_rd;
      rd_data  <= grant_rd ? cause_q : '0;
    end
  end

  // R6
  a_r6_cap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cap_exc |=> (cause_q.code == $past(cap_code) && cause_q.regn == $past(cap_reg)
                 && exc_code_q == EXC_CAP));
  // R7
  a_r7_generic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_exc && !cap_exc && !denied) |=> (cause_q == '0 && exc_code_q == $past(gen_code)));
  // R8
  a_r8_denied_access: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !pcc_sysreg && !cap_exc) |=> (cause_q.code == CODE_SYSREG && !rd_valid));
  // R10
  a_r10_low_set_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !sw_code_ok(set_code) && !enter) |=> $stable(cause_q));
endmodule

// File: rtl/cap_trap_unit.sv
module cap_trap_unit
  import cap_trap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_exc,
  input  logic [CODE_W-1:0]  cap_exc_code,
  input  logic [REGN_W-1:0]  cap_exc_reg,
  input  logic               gen_exc,
  input  logic [EXC_W-1:0]   gen_exc_code,
  input  logic [ADDR_W-1:0]  vec_offset,
  input  logic               eret,
  input  logic               pc_off_wr,
  input  logic [ADDR_W-1:0]  pc_off_data,
  input  logic               epcc_off_wr,
  input  logic [ADDR_W-1:0]  epcc_off_data,
  input  logic               kcc_wr,
  input  logic [CAP_W-1:0]   kcc_wdata,
  input  logic               cause_rd,
  input  logic               cause_set,
  input  logic [CODE_W-1:0]  cause_set_code,
  output logic [CAP_W-1:0]   pcc_o,
  output logic [CAP_W-1:0]   epcc_o,
  output logic [EXC_W-1:0]   exc_code_o,
  output logic               cause_rd_valid,
  output logic [CAUSE_W-1:0] cause_rd_data
);
  cap_t   pcc_w;
  cap_t   epcc_w;
  cap_t   kcc_in;
  cause_t rd_w;
  logic   enter_w;
  logic   sysreg_w;

  assign kcc_in   = kcc_wdata;
  assign sysreg_w = has_sysreg(pcc_w);

  cap_cause_reg u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_exc    (cap_exc),
    .cap_code   (cap_exc_code),
    .cap_reg    (cap_exc_reg),
    .gen_exc    (gen_exc),
    .gen_code   (gen_exc_code),
    .rd_req     (cause_rd),
    .set_req    (cause_set),
    .set_code   (cause_set_code),
    .pcc_sysreg (sysreg_w),
    .enter      (enter_w),
    .exc_code_q (exc_code_o),
    .rd_valid   (cause_rd_valid),
    .rd_data    (rd_w)
  );

  cap_pcc_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .enter         (enter_w),
    .eret          (eret),
    .vec_offset    (vec_offset),
    .pc_off_wr     (pc_off_wr),
    .pc_off_data   (pc_off_data),
    .epcc_off_wr   (epcc_off_wr),
    .epcc_off_data (epcc_off_data),
    .kcc_wr        (kcc_wr),
    .kcc_data      (kcc_in),
    .pcc_q         (pcc_w),
    .epcc_q        (epcc_w)
  );

  assign pcc_o         = pcc_w;
  assign epcc_o        = epcc_w;
  assign cause_rd_data = rd_w;

  // R12
  a_r12_fetch_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_off_wr && !enter_w && !eret) |=> pcc_w.offset == $past(pc_off_data));
endmodule

// File: tb/cap_trap_unit_test.sv
module cap_trap_unit_test;
  localparam int CW = 234;

  logic clk = 0;
  logic rst_n = 0;
  logic cap_exc = 0;
  logic [7:0] cap_exc_code = 0, cap_exc_reg = 0;
  logic gen_exc = 0;
  logic [4:0] gen_exc_code = 0;
  logic [63:0] vec_offset = 0;
  logic eret = 0, pc_off_wr = 0, epcc_off_wr = 0, kcc_wr = 0;
  logic [63:0] pc_off_data = 0, epcc_off_data = 0;
  logic [CW-1:0] kcc_wdata = 0;
  logic cause_rd = 0, cause_set = 0;
  logic [7:0] cause_set_code = 0;
  logic [CW-1:0] pcc_o, epcc_o;
  logic [4:0] exc_code_o;
  logic cause_rd_valid;
  logic [15:0] cause_rd_data;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cap_trap_unit uut (.*);

  function automatic logic [CW-1:0] mkcap(logic t, logic s, logic [15:0] p, logic [23:0] o,
                                          logic [63:0] b, logic [63:0] l, logic [63:0] off);
    return {t, s, p, o, b, l, off};
  endfunction

  function automatic logic [CW-1:0] boot(logic [63:0] off);
    return mkcap(1'b1, 1'b0, 16'hFFFF, 24'h0, 64'h0, {64{1'b1}}, off);
  endfunction

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cap_exc = 0; gen_exc = 0; eret = 0; pc_off_wr = 0; epcc_off_wr = 0;
    kcc_wr = 0; cause_rd = 0; cause_set = 0;
  endtask

  task automatic read_cause(string req, logic [15:0] exp);
    cause_rd = 1;
    tick();
    chk({req, " read valid"}, CW'(cause_rd_valid), CW'(1'b1));
    chk({req, " read data"}, CW'(cause_rd_data), CW'(exp));
  endtask

  task automatic t_reset();
    chk("R1 pcc", pcc_o, boot(64'h0));
    chk("R1 epcc", epcc_o, '0);
    chk("R1 exc code", CW'(exc_code_o), '0);
    read_cause("R1 cause", 16'h0000);
  endtask

  task automatic t_generic();
    pc_off_data = 64'h1000; pc_off_wr = 1;
    tick();
    chk("R12 fetch offset", pcc_o, boot(64'h1000));
    gen_exc = 1; gen_exc_code = 5'd4; vec_offset = 64'h180;
    tick();
    chk("R3 pcc vectored", pcc_o, boot(64'h180));
    chk("R2 epcc saved", epcc_o, boot(64'h1000));
    chk("R7 exc code", CW'(exc_code_o), CW'(5'd4));
    read_cause("R7 cause cleared", 16'h0000);
  endtask

  task automatic t_cap_exc();
    cap_exc = 1; cap_exc_code = 8'h02; cap_exc_reg = 8'h07;
    gen_exc = 1; gen_exc_code = 5'd9; vec_offset = 64'h180;
    tick();
    chk("R6 exc code 18", CW'(exc_code_o), CW'(5'd18));
    chk("R2 epcc on cap exc", epcc_o, boot(64'h180));
    read_cause("R6 cause", 16'h0207);
  endtask

  task automatic t_return();
    epcc_off_data = 64'h1004; epcc_off_wr = 1;
    tick();
    chk("R4 epcc patched", epcc_o, boot(64'h1004));
    eret = 1;
    tick();
    chk("R4 return", pcc_o, boot(64'h1004));
  endtask

  task automatic t_entry_wins();
    pc_off_data = 64'h2000; pc_off_wr = 1;
    tick();
    eret = 1; gen_exc = 1; gen_exc_code = 5'd3; vec_offset = 64'h200;
    tick();
    chk("R5 entry over return pcc", pcc_o, boot(64'h200));
    chk("R5 entry over return epcc", epcc_o, boot(64'h2000));
    gen_exc = 1; gen_exc_code = 5'd3; vec_offset = 64'h240;
    pc_off_data = 64'h9999; pc_off_wr = 1;
    tick();
    chk("R5 entry over offset write", pcc_o, boot(64'h240));
  endtask

  task automatic t_set();
    cap_exc = 1; cap_exc_code = 8'h05; cap_exc_reg = 8'h0C; vec_offset = 64'h80;
    tick();
    cause_set = 1; cause_set_code = 8'h85;
    tick();
    read_cause("R9 set high", 16'h850C);
    cause_set = 1; cause_set_code = 8'h7F;
    tick();
    read_cause("R10 low set ignored", 16'h850C);
    cause_set = 1; cause_set_code = 8'h80;
    tick();
    read_cause("R9 set boundary", 16'h800C);
  endtask

  task automatic t_kcc_perm();
    logic [CW-1:0] k;
    k = mkcap(1'b1, 1'b0, 16'hFBFF, 24'h0, 64'h4000, 64'h100, 64'h0);
    kcc_wdata = k; kcc_wr = 1;
    tick();
    pc_off_data = 64'h3000; pc_off_wr = 1;
    tick();
    gen_exc = 1; gen_exc_code = 5'd1; vec_offset = 64'h80;
    tick();
    chk("R11 new handler cap", pcc_o, mkcap(1'b1, 1'b0, 16'hFBFF, 24'h0, 64'h4000, 64'h100, 64'h80));
    chk("R11 epcc", epcc_o, boot(64'h3000));
    cause_rd = 1; vec_offset = 64'h300;
    tick();
    chk("R8 denied no data", CW'(cause_rd_valid), '0);
    chk("R8 denied exc code", CW'(exc_code_o), CW'(5'd18));
    chk("R8 denied redirect", pcc_o, mkcap(1'b1, 1'b0, 16'hFBFF, 24'h0, 64'h4000, 64'h100, 64'h300));
    kcc_wdata = boot(64'h0); kcc_wr = 1;
    tick();
    gen_exc = 1; gen_exc_code = 5'd2; vec_offset = 64'h100;
    tick();
    read_cause("R8 permission restored", 16'h0000);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_generic();
    t_cap_exc();
    t_return();
    t_entry_wins();
    t_set();
    t_kcc_perm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule